// File: doc/BRIEF.md
# Interrupt Source Crossbar Router

This block sits between a wide set of peripheral interrupt request lines and a narrower set of inputs on the interrupt controller. Each output line that the crossbar routes has a small register. The register holds the number of the source line that the output forwards. Software writes these registers through a simple memory-mapped bus and can read them back.

Outputs are level-sensitive and active high. Output 0 feeds the controller's first shared peripheral input, which is interrupt number 32. The rest follow in order.

Two kinds of output are set apart by parameter masks:
- A reserved output has no register and no address. The address map is packed around it.
- A bypass output is tied to one fixed source. It ignores whatever is written to its slot.

The register width is a build parameter and may be 1, 2 or 4 bytes. Any other width stops elaboration. On reset, each routed register is loaded with a safe default source index. Writing that value back is how software frees an output.

Top module: `irq_xbar`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every `irq_o` bit is low after that edge, and every routed register is loaded with `SAFE_IDX`.
- R2: The slot of a non-reserved output k is at byte address `REG_BYTES` × (number of non-reserved outputs with index below k). Reserved outputs occupy no slot.
- R3: A write to a routed slot takes effect when all three of these hold: `bus_we` is high, byte enables `[REG_BYTES-1:0]` are all set, and the value in `bus_wdata[8*REG_BYTES-1:0]` is below `N_SRC`. A read of the slot returns the stored index, zero-extended into `bus_rdata`.
- R4: Each routed output is a registered copy of the selected source. `irq_o[k]` after an edge equals `src_i[sel]` sampled at that edge.
- R5: A write to a routed slot with full byte enables and a value at or above `N_SRC` leaves the register unchanged. It raises `err_o` for exactly the one cycle that follows the write edge.
- R6: A bypass output follows its fixed source with one clock of latency. Writes to its slot change nothing. Reading its slot returns the fixed source index.
- R7: Reserved outputs are held low at all times.
- R8: A read at an address that is not a slot start returns zero. This covers unaligned addresses and addresses beyond the packed map. A write to such an address changes no register.
- R9: A write whose byte enables do not cover the full register width is ignored.
- R10: When a register write and source activity coincide at edge E, the output after E still reflects the old selection. The new selection is visible from edge E+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | N_SRC | Peripheral interrupt request levels |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_be | input | 4 | Byte enables |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| err_o | output | 1 | One-cycle pulse on a rejected out-of-range write |
| irq_o | output | N_OUT | Routed interrupt levels to the controller |

## Verification
A register write can land in the same cycle as a source level change on the output being rerouted. The bench provokes this by changing the source vector on the same clock edge that captures a new index. It then judges the output on the two following cycles: the first must follow the previously selected source and the second the newly selected one. The rest of the bench sweeps every valid index over every routed output. It also sends out-of-range values, partial byte enables, unaligned and unmapped addresses, and writes to the bypass slot, and compares each result against arithmetic done in the bench.

// File: rtl/irq_xbar.sv
module irq_xbar #(
  parameter int N_SRC = 12,
  parameter int N_OUT = 8,
  parameter int REG_BYTES = 1,
  parameter int ADDR_W = 8,
  parameter int SAFE_IDX = 11,
  parameter logic [N_OUT-1:0] RSV_MASK = 8'b0010_0100,
  parameter logic [N_OUT-1:0] BYP_MASK = 8'b0100_0000,
  parameter logic [N_OUT*8-1:0] BYP_SRC = 64'h0003_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata,
  output logic              err_o,
  output logic [N_OUT-1:0]  irq_o
);
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int REG_W = 8 * REG_BYTES;

  if (!(REG_BYTES == 1 || REG_BYTES == 2 || REG_BYTES == 4)) begin : g_bad_width
    $error("irq_xbar: REG_BYTES must be 1, 2 or 4");
  end
  if (SRC_W > REG_W) begin : g_bad_fit
    $error("irq_xbar: source index does not fit the register width");
  end

  function automatic int slot_ofs(int k);
    int n = 0;
    for (int j = 0; j < k; j++) if (!RSV_MASK[j]) n++;
    return n * REG_BYTES;
  endfunction

  wire [REG_W-1:0] wval = bus_wdata[REG_W-1:0];
  wire full_be = &bus_be[REG_BYTES-1:0];
  wire bad_val = 32'(wval) >= 32'(N_SRC);
  wire unused_bus = ^{bus_wdata, bus_be};

  logic [N_OUT-1:0] irq_d, wr_hit;
  logic [31:0] rd_part [N_OUT];
  logic err_q;
  logic [N_OUT-1:0] irq_q;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int OFS = slot_ofs(k);
    localparam logic [SRC_W-1:0] FIX = SRC_W'(BYP_SRC[k*8 +: 8]);
    if (RSV_MASK[k]) begin : g_rsv
      assign irq_d[k] = 1'b0;
      assign wr_hit[k] = 1'b0;
      assign rd_part[k] = '0;
      AST_RESERVED_QUIET: assert property (@(posedge clk) irq_o[k] == 1'b0); // R7
    end else begin : g_slot
      wire hit = bus_addr == ADDR_W'(OFS);
      if (BYP_MASK[k]) begin : g_byp
        assign irq_d[k] = src_i[FIX];
        assign wr_hit[k] = 1'b0;
        assign rd_part[k] = hit ? 32'(FIX) : 32'd0;
        AST_BYPASS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
          $past(rst_n) |-> irq_o[k] == $past(src_i[FIX])); // R6
      end else begin : g_route
        logic [SRC_W-1:0] sel_q;
        always_ff @(posedge clk) begin
          if (!rst_n) sel_q <= SRC_W'(SAFE_IDX);
          else if (bus_we && hit && full_be && !bad_val) sel_q <= wval[SRC_W-1:0];
        end
        assign irq_d[k] = src_i[sel_q];
        assign wr_hit[k] = hit;
        assign rd_part[k] = hit ? 32'(sel_q) : 32'd0;
        AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
          32'(sel_q) < 32'(N_SRC)); // R5
        AST_BAD_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
          (bus_we && hit && bad_val) |=> $stable(sel_q)); // R5
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int k = 0; k < N_OUT; k++) bus_rdata = bus_rdata | rd_part[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      err_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      err_q <= bus_we && full_be && (|wr_hit) && bad_val;
    end
  end

  assign irq_o = irq_q;
  assign err_o = err_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> irq_o == '0); // R1
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(bus_we && full_be && bad_val)); // R5
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(rst_n)); // R5
endmodule

// File: tb/irq_xbar_tb.sv
module irq_xbar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 12;
  localparam int NO = 8;
  localparam int RB = 2;
  localparam int SAFE = 11;
  localparam logic [NO-1:0] RSV = 8'b0010_0100;
  localparam logic [NO-1:0] BYP = 8'b0100_0000;
  localparam int BYP_OUT = 6;
  localparam int BYP_FIX = 3;

  logic clk = 0, rst_n = 0, bus_we = 0, err_o;
  logic [NS-1:0] src_i = '1;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [3:0] bus_be = 0;
  logic [NO-1:0] irq_o;
  int checks = 0, errors = 0;

  irq_xbar #(.N_SRC(NS), .N_OUT(NO), .REG_BYTES(RB), .ADDR_W(8), .SAFE_IDX(SAFE),
    .RSV_MASK(RSV), .BYP_MASK(BYP), .BYP_SRC(64'h0003_0000_0000_0000)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata), .err_o(err_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ofs(int k);
    int n = 0;
    for (int j = 0; j < k; j++) if (!RSV[j]) n++;
    return n * RB;
  endfunction

  function automatic bit routed(int k);
    return !RSV[k] && !BYP[k];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk); bus_we = 0; bus_be = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic set_src(input logic [NS-1:0] v);
    @(negedge clk); src_i = v;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 outputs low in reset", 32'(irq_o), 0);
    check("R1 err low in reset", 32'(err_o), 0);
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < NO; k++) begin
      if (RSV[k]) continue;
      bus_read(8'(ofs(k)), d);
      check(routed(k) ? "R1 R2 safe index at packed slot" : "R6 bypass reads fixed", d,
            routed(k) ? SAFE : BYP_FIX);
    end
    bus_read(8'(ofs(NO)), d); check("R8 beyond map reads zero", d, 0);
    bus_read(8'(ofs(NO) + RB), d); check("R8 beyond map reads zero", d, 0);
    bus_read(8'd1, d); check("R8 unaligned reads zero", d, 0);
    bus_read(8'd3, d); check("R8 unaligned reads zero", d, 0);

    // R3 R4 R7 sweep
    for (int k = 0; k < NO; k++) begin
      if (!routed(k)) continue;
      for (int s = 0; s < NS; s++) begin
        bus_write(8'(ofs(k)), 32'(s), 4'b0011);
        check("R5 no err on valid write", 32'(err_o), 0);
        bus_read(8'(ofs(k)), d);
        check("R3 readback", d, 32'(s));
        set_src(NS'(1) << s);
        check("R4 selected source high", 32'(irq_o[k]), 1);
        check("R7 reserved low", 32'(irq_o & RSV), 0);
        set_src(~(NS'(1) << s));
        check("R4 selected source low", 32'(irq_o[k]), 0);
        check("R7 reserved low", 32'(irq_o & RSV), 0);
      end
    end

    // R5 invalid values
    bus_write(8'(ofs(1)), 32'd6, 4'b0011);
    for (int v = NS; v < 16; v++) begin
      bus_write(8'(ofs(1)), 32'(v), 4'b0011);
      check("R5 err pulse", 32'(err_o), 1);
      @(negedge clk);
      check("R5 err one cycle", 32'(err_o), 0);
      bus_read(8'(ofs(1)), d);
      check("R5 register kept", d, 6);
    end

    // R9 partial enables
    bus_write(8'(ofs(3)), 32'd4, 4'b0011);
    bus_write(8'(ofs(3)), 32'd9, 4'b0001);
    bus_read(8'(ofs(3)), d); check("R9 low-byte enable ignored", d, 4);
    bus_write(8'(ofs(3)), 32'd9, 4'b0010);
    bus_read(8'(ofs(3)), d); check("R9 high-byte enable ignored", d, 4);

    // R8 writes to unaligned / unmapped
    bus_write(8'(ofs(0)), 32'd7, 4'b0011);
    bus_write(8'(ofs(0) + 1), 32'd2, 4'b0011);
    bus_read(8'(ofs(0)), d); check("R8 unaligned write ignored", d, 7);
    bus_write(8'(ofs(NO)), 32'd2, 4'b0011);
    for (int k = 0; k < NO; k++) begin
      if (!routed(k)) continue;
      bus_read(8'(ofs(k)), d);
      check("R8 unmapped write ignored", d, k == 0 ? 7 : k == 1 ? 6 : k == 3 ? 4 : 11);
    end

    // R6 bypass
    bus_write(8'(ofs(BYP_OUT)), 32'd8, 4'b0011);
    bus_read(8'(ofs(BYP_OUT)), d); check("R6 bypass write ignored", d, BYP_FIX);
    set_src(NS'(1) << BYP_FIX);
    check("R6 bypass follows fixed source", 32'(irq_o[BYP_OUT]), 1);
    set_src(~(NS'(1) << BYP_FIX));
    check("R6 bypass follows fixed source", 32'(irq_o[BYP_OUT]), 0);

    // R10 write and source change in same cycle
    bus_write(8'(ofs(4)), 32'd2, 4'b0011);
    set_src('0);
    @(negedge clk);
    bus_we = 1; bus_addr = 8'(ofs(4)); bus_wdata = 32'd9; bus_be = 4'b0011;
    src_i = NS'(1) << 2;
    @(negedge clk); bus_we = 0; bus_be = 0;
    check("R10 old selection after write edge", 32'(irq_o[4]), 1);
    @(negedge clk);
    check("R10 new selection next edge", 32'(irq_o[4]), 0);
    set_src(NS'(1) << 9);
    check("R10 new selection follows", 32'(irq_o[4]), 1);

    // R1 reset mid-run
    bus_write(8'(ofs(0)), 32'd5, 4'b0011);
    set_src('1);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R1 outputs cleared by reset", 32'(irq_o), 0);
    bus_read(8'(ofs(0)), d); check("R1 safe index reloaded", d, SAFE);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule